// File: doc/BRIEF.md
# Page Load Buffer Controller

This block handles the host-facing load phase of a memory that is programmed one page at a time. A host on a parallel bus writes single bytes with active-low chip enable, write enable and output enable strobes, a 17-bit address and an 8-bit data bus. The strobes are sampled on the system clock. Each accepted byte goes into a 128-byte page buffer. The host may load bytes in any order and may load only some of them.

When the host stops loading for longer than a timeout, the block programs the whole page into its storage array. It raises a busy flag for a fixed number of clock cycles. When the busy interval ends, the array takes the buffer contents. Any byte that was not loaded is stored as FFh. The buffer then returns to all FFh. Bytes aimed at a page other than the one opened by the first byte of the load phase are dropped and raise an error flag.

Reads use the same bus. With chip enable and output enable both low, the block drives the array byte at the current address. For simulation the array holds `ARRAY_PAGES` pages. Page numbers at or above that count alias onto the low page bits.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, busy and page_err are 0, and every array byte reads FFh.
- R2: dout_en is 1 exactly when ce_n and oe_n are both 0. When it is 1, dout shows the array byte at addr.
- R3: A byte write is active while ce_n=0, we_n=0 and oe_n=1. The address is taken in the first cycle the write is active, which is the later of the two falling edges. The data is taken from din in the first cycle that ce_n or we_n is seen high again, which is the earlier of the two rising edges.
- R4: Bytes of one page may be loaded in any order. Each one lands at offset addr[6:0] of the page addr[16:7].
- R5: When a page is programmed, every offset not loaded in that load phase is stored as FFh. This includes bytes that held data from an earlier program.
- R6: A load phase stays open while each new write starts within LOAD_TIMEOUT cycles of the previous byte's end. busy rises LOAD_TIMEOUT cycles after the last byte ends, if no new write starts in that window.
- R7: No byte is taken if oe_n is 0 when the write would start, or if oe_n falls while the write is active. Such cycles do not open a load phase.
- R8: busy stays high for exactly PROG_CYCLES cycles. Array reads show the old contents until busy falls.
- R9: A byte whose page differs from the open page is dropped and sets page_err. page_err clears when the next load phase opens.
- R10: Writes made while busy is high are dropped and do not open a load phase. The next load phase starts from an all-FFh buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address: page in [16:7], offset in [6:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable |
| busy | output | 1 | Page programming in progress |
| page_err | output | 1 | A byte for a foreign page was dropped |

## Verification
Faults in the strobe sampler would show as bytes stored at the wrong offset or with the wrong data. They would be visible on the first read after the next program, about LOAD_TIMEOUT plus PROG_CYCLES cycles later. A faulty load timer shows up as busy rising one or more cycles off from the expected edge, or a phase splitting in two. That is checked against windows just inside and just past the timeout. A buffer that fails to clear, or a wrong page register, leaves stale or foreign bytes in the array. The page checks read those bytes back directly, together with the error flag.

// File: rtl/plb_pkg.sv
package plb_pkg;
    // Controller phases: waiting for a first byte, collecting bytes, programming the array.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } plb_state_t;
endpackage

// File: rtl/plb_strobe_sync.sv
// Strobe sampler: finds the start and end of host byte writes from clock-sampled strobes.
// A write is active while ce_n=0, we_n=0 and oe_n=1. The address is latched in the first
// active cycle. The end pulse fires only when ce_n or we_n returns high while oe_n is still high.
// Assumes the strobes are already synchronous to clk.
module plb_strobe_sync #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_act,
    output logic              wr_start,
    output logic              wr_end,
    output logic [ADDR_W-1:0] addr_lat
);
    logic wr_q;

    assign wr_act   = !ce_n && !we_n && oe_n;
    assign wr_start = wr_act && !wr_q;
    assign wr_end   = wr_q && !wr_act && oe_n && (ce_n || we_n);

    // Track the previous write-active state.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= wr_act;
    end

    // Capture the address when a write starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_lat <= '0;
        else if (wr_start) addr_lat <= addr;
    end
endmodule

// File: rtl/plb_page_buf.sv
// Page buffer: holds one page of bytes, all FFh after reset or a clear.
// Assumes clr and wr_en are never asserted in the same cycle.
module plb_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [OFS_W-1:0]             wr_ofs,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [PAGE_BYTES*DATA_W-1:0] buf_flat
);
    logic [DATA_W-1:0] bytes_q [PAGE_BYTES];

    // Store one loaded byte, or fill the whole buffer with FFh.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= '1;
        end else if (wr_en) begin
            bytes_q[wr_ofs] <= wr_data;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign buf_flat[g*DATA_W +: DATA_W] = bytes_q[g];
    end

    AST_CLEAR_FILLS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (buf_flat[DATA_W-1:0] == '1 && buf_flat[PAGE_BYTES*DATA_W-1 -: DATA_W] == '1)); // R10
endmodule

// File: rtl/plb_array.sv
// Storage array: ARRAY_PAGES pages. A whole page is replaced in one cycle on commit.
// Reads are combinational. Assumes ARRAY_PAGES is a power of two and at least 2.
module plb_array #(
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 128,
    parameter int ARRAY_PAGES = 4,
    localparam int OFS_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = $clog2(ARRAY_PAGES),
    localparam int ARR_AW     = PG_W + OFS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit,
    input  logic [PG_W-1:0]              commit_page,
    input  logic [PAGE_BYTES*DATA_W-1:0] page_data,
    input  logic [ARR_AW-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data
);
    logic [DATA_W-1:0] mem [ARRAY_PAGES*PAGE_BYTES];

    // Erase on reset; on commit, overwrite every byte of the selected page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_PAGES*PAGE_BYTES; i++) mem[i] <= '1;
        end else if (commit) begin
            for (int b = 0; b < PAGE_BYTES; b++)
                mem[{commit_page, OFS_W'(b)}] <= page_data[b*DATA_W +: DATA_W];
        end
    end

    assign rd_data = mem[rd_addr];

    AST_ARRAY_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem[0])); // R8
endmodule

// File: rtl/page_load_ctrl.sv
// Page load controller (top).
// Collects host byte writes for one page, waits for a quiet gap of LOAD_TIMEOUT cycles,
// then spends PROG_CYCLES cycles programming and commits the buffer to the array.
// Assumes PROG_CYCLES >= 2 and LOAD_TIMEOUT >= 2.
module page_load_ctrl
    import plb_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 128,
    parameter int ARRAY_PAGES  = 4,
    parameter int LOAD_TIMEOUT = 15000,
    parameter int PROG_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    output logic              page_err
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int PG_W   = $clog2(ARRAY_PAGES);
    localparam int ARR_AW = PG_W + OFS_W;
    localparam int TMR_W  = $clog2(LOAD_TIMEOUT + 1);
    localparam int PCN_W  = $clog2(PROG_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LOAD_TIMEOUT - 1);
    localparam logic [PCN_W-1:0] PCN_LAST = PCN_W'(PROG_CYCLES - 1);

    plb_state_t                   state;
    logic [PAGE_W-1:0]            page_q;
    logic [TMR_W-1:0]             tmr;
    logic [PCN_W-1:0]             pcnt;
    logic                         wr_act, wr_start, wr_end;
    logic [ADDR_W-1:0]            addr_lat;
    logic                         same_page, buf_we, commit;
    logic [PAGE_BYTES*DATA_W-1:0] buf_flat;

    plb_strobe_sync #(.ADDR_W(ADDR_W)) strobe_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end), .addr_lat(addr_lat)
    );

    // Decide whether the ending byte goes into the buffer, and when to commit.
    always_comb begin
        same_page = (addr_lat[ADDR_W-1:OFS_W] == page_q);
        buf_we    = wr_end && ((state == ST_IDLE) || (state == ST_LOAD && same_page));
        commit    = (state == ST_PROG) && (pcnt == PCN_LAST);
    end

    plb_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr(commit), .wr_en(buf_we),
        .wr_ofs(addr_lat[OFS_W-1:0]), .wr_data(din), .buf_flat(buf_flat)
    );

    plb_array #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .ARRAY_PAGES(ARRAY_PAGES)) array_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page_q[PG_W-1:0]),
        .page_data(buf_flat), .rd_addr(addr[ARR_AW-1:0]), .rd_data(dout)
    );

    // Phase sequencing: open page, load timer, program counter, error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            page_q   <= '0;
            tmr      <= '0;
            pcnt     <= '0;
            page_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_end) begin
                        state    <= ST_LOAD;
                        page_q   <= addr_lat[ADDR_W-1:OFS_W];
                        tmr      <= '0;
                        page_err <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (wr_end && !same_page) page_err <= 1'b1;
                    if (wr_act || wr_end) begin
                        tmr <= '0;
                    end else if (tmr == TMR_LAST) begin
                        state <= ST_PROG;
                        pcnt  <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (pcnt == PCN_LAST) state <= ST_IDLE;
                    else                  pcnt  <= pcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_PROG);
    assign dout_en = !ce_n && !oe_n;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R8
    AST_PROG_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state == ST_LOAD && !wr_act)); // R6
    AST_ERR_ON_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_err) |-> $past(state == ST_LOAD && wr_end)); // R9
    AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_q)); // R10
endmodule

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb_top;
    localparam int LT = 20;
    localparam int PC = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, busy, page_err;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    page_load_ctrl #(.LOAD_TIMEOUT(LT), .PROG_CYCLES(PC), .ARRAY_PAGES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
    );

    // vector: {address, data} for one page loaded out of order
    localparam logic [24:0] VEC [6] = '{
        {17'h00085, 8'h11}, {17'h000F0, 8'h22}, {17'h00080, 8'h33},
        {17'h000FF, 8'h44}, {17'h000A3, 8'h55}, {17'h00091, 8'h66}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #2 d = dout;
        #3 ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_done(output int cnt);
        int guard = 0;
        cnt = 0;
        while (!busy && guard < 8*LT) begin @(negedge clk); guard++; end
        while (busy && cnt < 4*PC) begin cnt++; @(negedge clk); end
    endtask

    initial begin : watchdog
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 page_err", page_err, 0);
        chk("R2 dout_en idle", dout_en, 0);
        rd(17'h00090, d); chk("R1 erased byte", d, 8'hFF);
        ce_n = 1'b0; oe_n = 1'b1; #1 chk("R2 dout_en oe high", dout_en, 0); ce_n = 1'b1;

        // R6 timeout window: second byte inside the window keeps the phase open
        do_write(17'h00090, 8'h77);
        repeat (LT - 4) @(negedge clk);
        chk("R6 still loading", busy, 0);
        do_write(17'h00092, 8'h78);
        repeat (LT - 2) @(negedge clk);
        chk("R6 before timeout", busy, 0);
        repeat (3) @(negedge clk);
        chk("R6 after timeout", busy, 1);
        rd(17'h00092, d); chk("R8 old data while busy", d, 8'hFF);
        while (busy) @(negedge clk);
        rd(17'h00090, d); chk("R6 byte 0x090", d, 8'h77);
        rd(17'h00092, d); chk("R6 byte 0x092", d, 8'h78);

        // R4/R5 vector walk: out-of-order page load
        foreach (VEC[i]) do_write(VEC[i][24:8], VEC[i][7:0]);
        wait_done(c);
        chk("R8 busy length", c, PC);
        foreach (VEC[i]) begin
            rd(VEC[i][24:8], d); chk("R4 loaded byte", d, VEC[i][7:0]);
        end
        rd(17'h00090, d); chk("R5 old byte refilled", d, 8'hFF);
        rd(17'h00092, d); chk("R5 old byte refilled 2", d, 8'hFF);
        rd(17'h000FE, d); chk("R5 never loaded", d, 8'hFF);

        // R9 foreign page dropped, error flag set
        do_write(17'h00100, 8'hA1);
        do_write(17'h00180, 8'hB2);
        chk("R9 page_err set", page_err, 1);
        wait_done(c);
        rd(17'h00100, d); chk("R9 own page byte", d, 8'hA1);
        rd(17'h00180, d); chk("R9 foreign byte dropped", d, 8'hFF);
        chk("R9 page_err held", page_err, 1);

        // R10 writes during busy ignored; R9 error cleared on new phase
        do_write(17'h00000, 8'h5A);
        chk("R9 page_err cleared", page_err, 0);
        while (!busy) @(negedge clk);
        do_write(17'h00001, 8'hC3);
        while (busy) @(negedge clk);
        repeat (LT + 5) @(negedge clk);
        chk("R10 no phase from busy write", busy, 0);
        rd(17'h00000, d); chk("R10 byte before busy", d, 8'h5A);
        rd(17'h00001, d); chk("R10 busy write dropped", d, 8'hFF);

        // R7 inhibit: oe_n low from the start, and oe_n falling mid-write
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 17'h00002; din = 8'h12;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 17'h00005; din = 8'h99;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (LT + 5) @(negedge clk);
        chk("R7 no phase opened", busy, 0);
        rd(17'h00002, d); chk("R7 inhibited byte", d, 8'hFF);
        rd(17'h00005, d); chk("R7 aborted byte", d, 8'hFF);

        // R3 chip-enable-controlled write with address/data changes
        @(negedge clk); we_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; addr = 17'h00003; din = 8'hEE;
        @(negedge clk); ce_n = 1'b0; addr = 17'h00004; din = 8'h21;
        @(negedge clk); addr = 17'h00006; din = 8'h42;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        wait_done(c);
        rd(17'h00004, d); chk("R3 later-fall address, earlier-rise data", d, 8'h42);
        rd(17'h00003, d); chk("R3 pre-enable address unused", d, 8'hFF);
        rd(17'h00006, d); chk("R3 late address unused", d, 8'hFF);
        rd(17'h00000, d); chk("R5 page 0 reprogrammed", d, 8'hFF);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; #1 chk("R2 dout_en read", dout_en, 1);
        ce_n = 1'b1; oe_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule